// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This block takes received frames as a byte stream and files each frame into memory under the control of a ring of descriptors. Software builds the ring in a descriptor RAM. For each slot it sets the buffer address and capacity and marks the slot active. The engine walks the ring one slot at a time. It reads a slot's three words and streams the frame bytes into the named buffer through a byte-wide buffer write port. When the frame ends, it writes back the stored length and then a status word. That status word clears the active flag and can mark the frame as bad.

The incoming stream uses valid/ready. A beat moves only in a cycle where `rx_valid` and `rx_ready` are both high. The engine lowers `rx_ready` while it fetches a descriptor, while it writes one back, and while a software reset is in progress. The source must then hold the beat steady. When the engine finds a slot that is not active, it stops. While stopped, it keeps `rx_ready` high and discards every frame that arrives, counting each one. A one-cycle pulse on `rx_req` restarts the walk from the slot where it stopped. A pulse on `sw_rst` starts a fixed-length reset. During that reset `sw_rst_busy` reads 1.

Top module: `rx_desc_ring`

## Requirements
- R1: Slot i occupies four descriptor-RAM words starting at word address {ring_base[DESC_AW-1:2] + i, 2'b00}.
  - Word 0 holds the status: bit 31 is active, bit 30 is end-of-ring and bit 27 is frame error.
  - Word 1 holds the capacity in bits 31:16 and the stored length in bits 15:0.
  - Word 2 holds the byte address of the buffer.
- R2: The k-th accepted byte of a frame stored in a slot is written to buffer address (word 2 + k). Exactly one buffer write occurs per stored byte, in the same cycle as its handshake.
- R3: After the last byte of a stored frame, the engine writes word 1 as {capacity, stored length}. In the following cycle it writes word 0 with active = 0, end-of-ring copied from the fetched status, the error flag, and all other bits 0. Neither write happens before the last data byte has been written.
- R4: The error flag in the written-back status is 1 when `rx_err` was high on any accepted beat of the frame.
- R5: A frame longer than the capacity has only its first capacity bytes stored. The remaining bytes are still accepted and then discarded. The stored length equals the capacity and the error flag is set.
- R6: After a slot whose end-of-ring flag is set, the next slot is slot 0. Otherwise the next slot is the current index plus one.
- R7: When a fetched status word has active = 0, the engine stops (`rx_running` = 0).
  - Only an `rx_req` pulse restarts it, and that pulse has an effect only while the engine is stopped and is not in the middle of discarding a frame.
  - On restart, the engine refetches the same slot.
- R8: While stopped, the engine holds `rx_ready` high, accepts frames and discards them. `missed_cnt` increases by one on the last byte of each discarded frame.
- R9: `rx_ready` is low while a descriptor is being fetched or written back. No buffer write happens without a handshake. The descriptor read and write strobes are never high together.
- R10: An `sw_rst` pulse raises `sw_rst_busy` from the next cycle for RST_CYCLES cycles.
  - During that time `rx_ready` and both descriptor strobes stay low.
  - Afterwards the engine is stopped at slot 0 with `missed_cnt` = 0.
- R11: After `rst_n` is released, the engine is stopped at slot 0, `missed_cnt` is 0, `sw_rst_busy` is 0 and `rx_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | Byte beat valid |
| rx_ready | output | 1 | Engine can take a beat |
| rx_data | input | 8 | Frame byte |
| rx_last | input | 1 | Beat is the last byte of the frame |
| rx_err | input | 1 | Receive error seen on this beat |
| ring_base | input | DESC_AW | Word address of slot 0 (low two bits unused) |
| rx_req | input | 1 | Pulse: restart a stopped engine |
| sw_rst | input | 1 | Pulse: start a software reset |
| sw_rst_busy | output | 1 | Software reset in progress |
| rx_running | output | 1 | Engine is walking the ring |
| missed_cnt | output | MISS_W | Count of discarded frames |
| desc_re | output | 1 | Descriptor RAM read strobe (data on the next cycle) |
| desc_we | output | 1 | Descriptor RAM write strobe |
| desc_addr | output | DESC_AW | Descriptor RAM word address |
| desc_wdata | output | 32 | Descriptor RAM write data |
| desc_rdata | input | 32 | Descriptor RAM read data |
| buf_we | output | 1 | Buffer byte write strobe |
| buf_addr | output | BUF_AW | Buffer byte address |
| buf_wdata | output | 8 | Buffer byte |

## Verification
The hardest situation to reach is the engine stopping exactly after an end-of-ring slot. The ring must be fully consumed so that the wrap lands on a slot that software has not yet re-armed. The bench gets there by filling all four slots of a ring whose last slot carries the end-of-ring flag. It then re-arms only part of the ring and pulses `rx_req`, so the wrap, the stop and the resulting discarded frames all follow one another. A later software reset, issued while the ring index sits mid-ring, shows that the index returns to slot 0.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  typedef enum logic [2:0] {
    ST_STOP, ST_RD0, ST_RD1, ST_RD2, ST_RD3, ST_RX, ST_WB1, ST_WB0
  } rxr_state_e;

  localparam int ACT_BIT = 31;
  localparam int EOL_BIT = 30;
  localparam int ERR_BIT = 27;

  localparam logic [1:0] W_STAT = 2'd0;
  localparam logic [1:0] W_SIZE = 2'd1;
  localparam logic [1:0] W_BUF  = 2'd2;
endpackage

// File: rtl/rxr_rst_seq.sv
module rxr_rst_seq #(
  parameter int RST_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int CW = $clog2(RST_CYCLES + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (start)        cnt <= CW'(RST_CYCLES);
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);
endmodule

// File: rtl/rxr_miss_cnt.sv
module rxr_miss_cnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] value
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     value <= '0;
    else if (clr)   value <= '0;
    else if (inc)   value <= value + 1'b1;
  end
endmodule

// File: rtl/rxr_fill.sv
module rxr_fill #(
  parameter int AW = 32,
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_addr,
  input  logic [LW-1:0] cap,
  input  logic          beat,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [LW-1:0] stored,
  output logic          overflow
);
  logic [AW-1:0] base;
  logic          room;

  assign room    = (stored < cap);
  assign wr_en   = beat && room;
  assign wr_addr = base + AW'(stored);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base     <= '0;
      stored   <= '0;
      overflow <= 1'b0;
    end else if (load) begin
      base     <= load_addr;
      stored   <= '0;
      overflow <= 1'b0;
    end else if (beat) begin
      if (room) stored   <= stored + 1'b1;
      else      overflow <= 1'b1;
    end
  end
endmodule

// File: rtl/rx_desc_ring.sv
module rx_desc_ring
  import rxr_pkg::*;
#(
  parameter int DESC_AW    = 10,
  parameter int IDX_W      = 4,
  parameter int BUF_AW     = 32,
  parameter int MISS_W     = 16,
  parameter int RST_CYCLES = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rx_valid,
  output logic               rx_ready,
  input  logic [7:0]         rx_data,
  input  logic               rx_last,
  input  logic               rx_err,
  input  logic [DESC_AW-1:0] ring_base,
  input  logic               rx_req,
  input  logic               sw_rst,
  output logic               sw_rst_busy,
  output logic               rx_running,
  output logic [MISS_W-1:0]  missed_cnt,
  output logic               desc_re,
  output logic               desc_we,
  output logic [DESC_AW-1:0] desc_addr,
  output logic [31:0]        desc_wdata,
  input  logic [31:0]        desc_rdata,
  output logic               buf_we,
  output logic [BUF_AW-1:0]  buf_addr,
  output logic [7:0]         buf_wdata
);
  localparam int SLOT_W = DESC_AW - 2;
  localparam int LEN_W  = 16;

  rxr_state_e         state;
  logic [IDX_W-1:0]   idx;
  logic               eol_r;
  logic               err_acc;
  logic               in_drop;
  logic [LEN_W-1:0]   cap_r;
  logic               hold;
  logic               accept;
  logic [LEN_W-1:0]   stored;
  logic               overflow;
  logic [1:0]         word;
  logic [SLOT_W-1:0]  slot;
  logic [31:0]        status_wb;
  logic               unused_bits;

  assign unused_bits = ^ring_base[1:0];

  rxr_rst_seq #(.RST_CYCLES(RST_CYCLES)) u_rst (
    .clk(clk), .rst_n(rst_n), .start(sw_rst), .busy(sw_rst_busy)
  );

  assign hold     = sw_rst || sw_rst_busy;
  assign rx_ready = !hold && (state == ST_STOP || state == ST_RX);
  assign accept   = rx_valid && rx_ready;

  rxr_miss_cnt #(.W(MISS_W)) u_miss (
    .clk(clk), .rst_n(rst_n), .clr(hold),
    .inc(accept && rx_last && state == ST_STOP),
    .value(missed_cnt)
  );

  rxr_fill #(.AW(BUF_AW), .LW(LEN_W)) u_fill (
    .clk(clk), .rst_n(rst_n),
    .load(state == ST_RD3),
    .load_addr(desc_rdata[BUF_AW-1:0]),
    .cap(cap_r),
    .beat(accept && state == ST_RX),
    .wr_en(buf_we), .wr_addr(buf_addr),
    .stored(stored), .overflow(overflow)
  );
  assign buf_wdata = rx_data;

  // sequencing of the ring walk
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_STOP;
      idx     <= '0;
      eol_r   <= 1'b0;
      err_acc <= 1'b0;
      in_drop <= 1'b0;
      cap_r   <= '0;
    end else if (hold) begin
      state   <= ST_STOP;
      idx     <= '0;
      err_acc <= 1'b0;
      in_drop <= 1'b0;
    end else begin
      case (state)
        ST_STOP: begin
          if (accept) in_drop <= !rx_last;
          if (rx_req && !in_drop && !accept) state <= ST_RD0;
        end
        ST_RD0: state <= ST_RD1;
        ST_RD1: begin
          if (desc_rdata[ACT_BIT]) begin
            eol_r <= desc_rdata[EOL_BIT];
            state <= ST_RD2;
          end else begin
            state <= ST_STOP;
          end
        end
        ST_RD2: begin
          cap_r <= desc_rdata[31:16];
          state <= ST_RD3;
        end
        ST_RD3: begin
          err_acc <= 1'b0;
          state   <= ST_RX;
        end
        ST_RX: begin
          if (accept) begin
            if (rx_err)  err_acc <= 1'b1;
            if (rx_last) state   <= ST_WB1;
          end
        end
        ST_WB1: state <= ST_WB0;
        ST_WB0: begin
          idx   <= eol_r ? '0 : idx + 1'b1;
          state <= ST_RD0;
        end
        default: state <= ST_STOP;
      endcase
    end
  end

  always_comb begin
    status_wb          = '0;
    status_wb[EOL_BIT] = eol_r;
    status_wb[ERR_BIT] = err_acc || overflow;
  end

  always_comb begin
    desc_re    = 1'b0;
    desc_we    = 1'b0;
    word       = W_STAT;
    desc_wdata = '0;
    case (state)
      ST_RD0: begin desc_re = 1'b1; word = W_STAT; end
      ST_RD1: begin desc_re = 1'b1; word = W_SIZE; end
      ST_RD2: begin desc_re = 1'b1; word = W_BUF;  end
      ST_WB1: begin
        desc_we    = 1'b1;
        word       = W_SIZE;
        desc_wdata = {cap_r, stored};
      end
      ST_WB0: begin
        desc_we    = 1'b1;
        word       = W_STAT;
        desc_wdata = status_wb;
      end
      default: ;
    endcase
  end

  assign slot       = ring_base[DESC_AW-1:2] + SLOT_W'(idx);
  assign desc_addr  = {slot, word};
  assign rx_running = (state != ST_STOP);
endmodule

// File: rtl/rxr_chk.sv
module rxr_chk #(
  parameter int MISS_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rx_valid,
  input logic              rx_ready,
  input logic              sw_rst,
  input logic              sw_rst_busy,
  input logic [MISS_W-1:0] missed_cnt,
  input logic              desc_re,
  input logic              desc_we,
  input logic [1:0]        word_sel,
  input logic              stat_active,
  input logic              buf_we
);
  // R9
  no_rw_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(desc_re && desc_we));
  // R9
  buf_handshake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    buf_we |-> (rx_valid && rx_ready));
  // R3
  status_clears_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_we && word_sel == 2'd0) |-> !stat_active);
  // R3
  length_before_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_we && word_sel == 2'd0) |-> ($past(desc_we) && $past(word_sel) == 2'd1));
  // R10
  reset_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_rst |=> sw_rst_busy);
  // R10
  reset_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_rst_busy |-> (!rx_ready && !desc_re && !desc_we));
  // R8
  missed_monotonic_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_rst && !sw_rst_busy) |=> (missed_cnt >= $past(missed_cnt)));
endmodule

bind rx_desc_ring rxr_chk #(.MISS_W(MISS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_ready(rx_ready),
  .sw_rst(sw_rst), .sw_rst_busy(sw_rst_busy), .missed_cnt(missed_cnt),
  .desc_re(desc_re), .desc_we(desc_we), .word_sel(desc_addr[1:0]),
  .stat_active(desc_wdata[31]), .buf_we(buf_we)
);

// File: tb/rx_desc_ring_tb.sv
module rx_desc_ring_tb;
  localparam int DESC_AW = 10;
  localparam int RSTC    = 4;
  localparam logic [9:0] RB = 10'h040;

  logic clk = 0;
  logic rst_n = 0;
  logic rx_valid = 0, rx_last = 0, rx_err = 0, rx_req = 0, sw_rst = 0;
  logic [7:0] rx_data = 0;
  logic rx_ready, sw_rst_busy, rx_running, desc_re, desc_we, buf_we;
  logic [15:0] missed_cnt;
  logic [9:0] desc_addr;
  logic [31:0] desc_wdata, desc_rdata, buf_addr;
  logic [7:0] buf_wdata;

  always #4 clk = ~clk;

  rx_desc_ring #(.RST_CYCLES(RSTC)) u_dut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_data(rx_data), .rx_last(rx_last), .rx_err(rx_err),
    .ring_base(RB), .rx_req(rx_req), .sw_rst(sw_rst),
    .sw_rst_busy(sw_rst_busy), .rx_running(rx_running),
    .missed_cnt(missed_cnt), .desc_re(desc_re), .desc_we(desc_we),
    .desc_addr(desc_addr), .desc_wdata(desc_wdata), .desc_rdata(desc_rdata),
    .buf_we(buf_we), .buf_addr(buf_addr), .buf_wdata(buf_wdata)
  );

  // descriptor RAM
  logic [31:0] dmem [0:1023];
  always @(posedge clk) begin
    if (desc_re) desc_rdata <= dmem[desc_addr];
    if (desc_we) dmem[desc_addr] <= desc_wdata;
  end

  // behavioural reference state
  bit          m_act [0:15];
  bit          m_eol [0:15];
  int          m_cap [0:15];
  int          m_buf [0:15];
  int          m_idx = 0;
  bit          m_run = 0;
  int          m_missed = 0;
  logic [31:0] eb_addr[$];
  logic [7:0]  eb_data[$];
  logic [9:0]  ed_addr[$];
  logic [31:0] ed_data[$];

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag,
                     input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // per-clock comparison of every memory write against the model
  always begin
    @(negedge clk); #2;
    if (rst_n && buf_we) begin
      if (eb_addr.size() == 0)
        chk(0, "R2 unexpected buffer write", {32'h0, buf_addr}, 64'h0);
      else begin
        logic [31:0] a; logic [7:0] d;
        a = eb_addr.pop_front(); d = eb_data.pop_front();
        chk(buf_addr == a && buf_wdata == d, "R2/R5 buffer write",
            {buf_addr, 24'h0, buf_wdata}, {a, 24'h0, d});
      end
    end
    if (rst_n && desc_we) begin
      if (ed_addr.size() == 0)
        chk(0, "R3 unexpected descriptor write", {54'h0, desc_addr}, 64'h0);
      else begin
        logic [9:0] a; logic [31:0] d;
        a = ed_addr.pop_front(); d = ed_data.pop_front();
        chk(desc_addr == a && desc_wdata == d, "R1/R3/R4/R5/R6 descriptor write",
            {22'h0, desc_addr, desc_wdata}, {22'h0, a, d});
      end
    end
  end

  task automatic arm(input int i, input int cap, input int bufa, input bit eol);
    dmem[RB + 4*i]     = {1'b1, eol, 30'h0};
    dmem[RB + 4*i + 1] = {cap[15:0], 16'h0};
    dmem[RB + 4*i + 2] = bufa;
    m_act[i] = 1; m_eol[i] = eol; m_cap[i] = cap; m_buf[i] = bufa;
  endtask

  task automatic send_frame(input int n, input int err_pos, input int seed);
    if (m_run && m_act[m_idx]) begin
      int ns; bit bad;
      ns  = (n < m_cap[m_idx]) ? n : m_cap[m_idx];
      bad = (err_pos >= 0) || (n > m_cap[m_idx]);
      for (int k = 0; k < ns; k++) begin
        eb_addr.push_back(m_buf[m_idx] + k);
        eb_data.push_back(8'(seed + k));
      end
      ed_addr.push_back(10'(RB + 4*m_idx + 1));
      ed_data.push_back({m_cap[m_idx][15:0], ns[15:0]});
      ed_addr.push_back(10'(RB + 4*m_idx));
      ed_data.push_back({1'b0, m_eol[m_idx], 2'b0, bad, 27'h0});
      m_act[m_idx] = 0;
      m_idx = m_eol[m_idx] ? 0 : (m_idx + 1) % 16;
      if (!m_act[m_idx]) m_run = 0;
    end else begin
      m_missed++;
    end
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      rx_valid = 1; rx_data = 8'(seed + k);
      rx_last = (k == n - 1); rx_err = (k == err_pos);
      #1;
      while (!rx_ready) begin @(negedge clk); #1; end
      @(posedge clk);
    end
    @(negedge clk);
    rx_valid = 0; rx_last = 0; rx_err = 0;
  endtask

  task automatic settle(input string tag);
    repeat (12) @(negedge clk);
    #2;
    chk(missed_cnt == 16'(m_missed), {tag, " R8 missed count"}, missed_cnt, m_missed);
    chk(rx_running == m_run, {tag, " R7 running"}, rx_running, m_run);
    chk(eb_addr.size() == 0 && ed_addr.size() == 0, {tag, " R3 writes pending"},
        eb_addr.size() + ed_addr.size(), 0);
  endtask

  task automatic req();
    bit was_stopped;
    was_stopped = !m_run;
    @(negedge clk); rx_req = 1;
    @(negedge clk); rx_req = 0; #1;
    if (was_stopped) begin
      chk(rx_ready == 0, "R9 ready low during fetch", rx_ready, 0);
      m_run = m_act[m_idx];
    end
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) dmem[i] = 32'h0;
    for (int i = 0; i < 16; i++) begin m_act[i] = 0; m_eol[i] = 0; m_cap[i] = 0; m_buf[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #2;
    // R11 reset state
    chk(rx_running == 0, "R11 running after reset", rx_running, 0);
    chk(missed_cnt == 0, "R11 missed after reset", missed_cnt, 0);
    chk(sw_rst_busy == 0, "R11 busy after reset", sw_rst_busy, 0);
    chk(rx_ready == 1, "R11 ready after reset", rx_ready, 1);

    // R8 frame before any request is dropped
    send_frame(3, -1, 8'h10);
    settle("drop-before-start");

    arm(0, 16, 32'h1000, 0);
    arm(1, 16, 32'h2000, 0);
    arm(2, 4,  32'h3000, 0);
    arm(3, 16, 32'h4000, 1);
    req();
    send_frame(5, -1, 8'h20);   // R2 R3 plain frame
    settle("slot0");
    send_frame(8, 3, 8'h40);    // R4 error mid-frame
    settle("slot1");
    send_frame(7, -1, 8'h60);   // R5 truncation
    settle("slot2");
    send_frame(1, -1, 8'h80);   // R6 end-of-ring slot, then R7 stop
    settle("slot3");
    send_frame(2, -1, 8'h90);   // R8 dropped after ring exhausted
    settle("exhausted");

    arm(0, 16, 32'h5000, 0);
    arm(1, 8,  32'h6000, 0);
    req();
    send_frame(6, -1, 8'hA0);   // R6 wrapped to slot 0
    send_frame(3, -1, 8'hB0);
    settle("wrapped");
    req();                      // R7 restart on inactive slot stops again
    settle("restart-inactive");

    // R10 software reset
    @(negedge clk); sw_rst = 1;
    @(negedge clk); sw_rst = 0; #2;
    for (int c = 0; c < RSTC; c++) begin
      chk(sw_rst_busy == 1, "R10 busy during reset", sw_rst_busy, 1);
      chk(rx_ready == 0, "R10 ready held low", rx_ready, 0);
      @(negedge clk); #2;
    end
    chk(sw_rst_busy == 0, "R10 busy released", sw_rst_busy, 0);
    m_missed = 0; m_run = 0; m_idx = 0;
    settle("after-reset R10");

    arm(0, 16, 32'h7000, 1);    // R10 index back at slot 0
    req();
    send_frame(4, -1, 8'hC0);
    settle("single-slot");
    arm(0, 2, 32'h7100, 1);
    req();
    send_frame(5, 1, 8'hD0);    // R4 R5 both causes
    settle("final");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 100000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule